// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns a single multi-register load or store into a stream of single-word memory accesses. A start strobe captures a 16-bit register mask, a base address, a writeback enable and a load/store flag. The sequencer then presents one access per set bit of the mask. Each access carries the register number and a word address. Registers are visited from the lowest number upward, and the addresses climb by four bytes from the base. This is the increment-after form of addressing.

When the last access has been accepted, the block pulses a completion strobe. In the same cycle it shows the updated base for writeback: the original base plus four bytes per transferred register. A load whose mask includes the top register (the program counter) is flagged as a subroutine return. The memory side throttles the stream with a ready input. The register file and the memory itself sit outside this block.

Top module: `lsm_seq`

## Requirements
- R1: After reset, acc_valid_o, done_o, wb_valid_o, ret_o and busy_o are all 0, and wb_value_o is 0.
- R2: Accesses are issued only for set bits of reg_list_i, each exactly once, in strictly ascending register number (acc_reg_o bit k of the mask ⇔ register k).
- R3: The first access address equals base_i; each later access address is the previous one plus 4, modulo 2^AW.
- R4: An access is accepted on a rising edge where acc_valid_o and mem_ready_i are both 1, so at most one is accepted per cycle; while mem_ready_i is 0, acc_reg_o and acc_addr_o hold their values.
- R5: done_o is high for exactly one cycle, namely the cycle right after the edge that accepted the last access, and acc_valid_o is 0 in that cycle.
- R6: While done_o is high, wb_value_o equals base_i + 4 × (number of set bits in reg_list_i), and wb_valid_o equals the captured writeback enable.
- R7: A start with an all-zero mask issues no access; done_o is high in the cycle after the start edge, and wb_value_o equals base_i unchanged.
- R8: start_i is ignored while busy_o is 1. Inputs presented then do not change the running sequence's registers, addresses or writeback value.
- R9: ret_o is high together with done_o exactly when the operation is a load (load_i = 1) and bit 15 of the mask is set; otherwise it stays 0.
- R10: For a non-empty mask, acc_valid_o is 1 in the cycle right after the start edge, and busy_o stays 1 until done_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| reg_list_i | input | 16 | Register mask, bit k selects register k |
| base_i | input | AW | Base byte address |
| wb_en_i | input | 1 | Request base writeback |
| load_i | input | 1 | 1 = load, 0 = store |
| mem_ready_i | input | 1 | Memory accepts the presented access |
| acc_valid_o | output | 1 | An access is presented |
| acc_reg_o | output | 4 | Register number of the access |
| acc_addr_o | output | AW | Word address of the access |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback requested (with done_o) |
| wb_value_o | output | AW | Updated base value |
| ret_o | output | 1 | Load included the program counter |

## Verification
The first access is due one edge after the start edge. Each following access is due one edge after the acceptance of the one before. The completion pulse, the writeback value and the return flag are due one edge after the final acceptance; for an empty mask they are due one edge after the start. The bench drives inputs on falling edges and reads outputs on the next falling edge. Every comparison is therefore made half a cycle after the rising edge that produced the value. The bench keeps its own count of accepted accesses, chosen from the ready pattern it drives, and from that count it derives the expected register, address and the cycle of the completion pulse.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_t;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int unsigned N  = 16,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + CW'(mask_i[i]);
    end
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            wb_en_i,
  input  logic            load_i,
  input  logic            mem_ready_i,
  output logic            acc_valid_o,
  output logic [IW-1:0]   acc_reg_o,
  output logic [AW-1:0]   acc_addr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_value_o,
  output logic            ret_o
);
  sq_state_t       state_q;
  logic [NREG-1:0] rem_q;
  logic            wb_en_q;
  logic            ret_q;

  logic [NREG-1:0] rest;
  logic [NREG-1:0] pick_in;
  logic            pick_any;
  logic [IW-1:0]   pick_idx;
  logic [CW-1:0]   list_cnt;
  logic            take;

  assign take    = acc_valid_o && mem_ready_i;
  assign rest    = rem_q & (rem_q - 1'b1);
  assign pick_in = (state_q == SQ_IDLE) ? reg_list_i : rest;
  assign busy_o  = (state_q != SQ_IDLE);

  lsm_lowbit #(.N(NREG)) u_pick (
    .mask_i (pick_in),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  lsm_popcnt #(.N(NREG)) u_cnt (
    .mask_i (reg_list_i),
    .cnt_o  (list_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      rem_q       <= '0;
      wb_en_q     <= 1'b0;
      ret_q       <= 1'b0;
      acc_valid_o <= 1'b0;
      acc_reg_o   <= '0;
      acc_addr_o  <= '0;
      done_o      <= 1'b0;
      wb_valid_o  <= 1'b0;
      wb_value_o  <= '0;
      ret_o       <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          done_o     <= 1'b0;
          wb_valid_o <= 1'b0;
          ret_o      <= 1'b0;
          if (start_i) begin
            rem_q      <= reg_list_i;
            wb_en_q    <= wb_en_i;
            ret_q      <= load_i && reg_list_i[NREG-1];
            wb_value_o <= base_i + (AW'(list_cnt) * AW'(WORD_BYTES));
            if (pick_any) begin
              acc_valid_o <= 1'b1;
              acc_reg_o   <= pick_idx;
              acc_addr_o  <= base_i;
              state_q     <= SQ_RUN;
            end else begin
              done_o     <= 1'b1;
              wb_valid_o <= wb_en_i;
              state_q    <= SQ_FIN;
            end
          end
        end
        SQ_RUN: begin
          if (take) begin
            rem_q <= rest;
            if (pick_any) begin
              acc_reg_o  <= pick_idx;
              acc_addr_o <= acc_addr_o + AW'(WORD_BYTES);
            end else begin
              acc_valid_o <= 1'b0;
              done_o      <= 1'b1;
              wb_valid_o  <= wb_en_q;
              ret_o       <= ret_q;
              state_q     <= SQ_FIN;
            end
          end
        end
        default: begin
          done_o     <= 1'b0;
          wb_valid_o <= 1'b0;
          ret_o      <= 1'b0;
          state_q    <= SQ_IDLE;
        end
      endcase
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_o && !mem_ready_i) |=>
      (acc_valid_o && $stable(acc_reg_o) && $stable(acc_addr_o)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!acc_valid_o || acc_addr_o == $past(acc_addr_o) + AW'(WORD_BYTES)));

  // R2
  reg_order_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!acc_valid_o || acc_reg_o > $past(acc_reg_o)));

  // R2
  reg_in_list_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid_o |-> rem_q[acc_reg_o]);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !acc_valid_o);

  // R9
  ret_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    ret_o |-> done_o);
endmodule

// File: tb/lsm_seq_test.sv
module lsm_seq_test;
  localparam int AW = 32;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [15:0]   reg_list_i = '0;
  logic [AW-1:0] base_i = '0;
  logic          wb_en_i = 1'b0;
  logic          load_i = 1'b0;
  logic          mem_ready_i = 1'b0;
  logic          acc_valid_o;
  logic [3:0]    acc_reg_o;
  logic [AW-1:0] acc_addr_o;
  logic          busy_o, done_o, wb_valid_o, ret_o;
  logic [AW-1:0] wb_value_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsm_seq #(.NREG(16), .AW(AW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .reg_list_i(reg_list_i),
    .base_i(base_i), .wb_en_i(wb_en_i), .load_i(load_i),
    .mem_ready_i(mem_ready_i), .acc_valid_o(acc_valid_o),
    .acc_reg_o(acc_reg_o), .acc_addr_o(acc_addr_o), .busy_o(busy_o),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_value_o(wb_value_o),
    .ret_o(ret_o)
  );

  // vector: list, base, wb_en, load, stall period (0 = always ready), expected final base
  localparam logic [15:0]   V_LIST [NV] = '{16'h00C3, 16'h8001, 16'hFFFF, 16'h0400, 16'h5A5A, 16'h8000};
  localparam logic [AW-1:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h0100, 32'hFFFF_FFFC, 32'h0040, 32'h0008};
  localparam logic          V_WB   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic          V_LD   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int            V_PER  [NV] = '{0, 3, 2, 0, 4, 0};
  localparam logic [AW-1:0] V_EXP  [NV] = '{32'h1010, 32'h2008, 32'h0140, 32'h0000_0000, 32'h0060, 32'h000C};

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int next_bit(input logic [15:0] m, input int from);
    for (int i = from; i < 16; i++) if (m[i]) return i;
    return 16;
  endfunction

  // junk > 0: start_i held high with other inputs for that many stalled cycles
  task automatic run_seq(input logic [15:0] lst, input logic [AW-1:0] base, input logic wb,
                         input logic ld, input int per, input logic [AW-1:0] exp_fin, input int junk);
    int k = 0;
    int cnt = $countones(lst);
    int nb = next_bit(lst, 0);
    int t = 0;
    bit r;
    @(negedge clk);
    start_i = 1; reg_list_i = lst; base_i = base; wb_en_i = wb; load_i = ld; mem_ready_i = 0;
    @(negedge clk);
    start_i = 0; reg_list_i = 16'h0; base_i = 32'hDEAD_0000; wb_en_i = ~wb; load_i = ~ld;
    if (cnt == 0) begin
      check(done_o == 1 && acc_valid_o == 0, "R7 empty done", {done_o, acc_valid_o}, 2'b10);
      check(wb_value_o == base, "R7 base unchanged", wb_value_o, base);
      @(negedge clk);
      check(done_o == 0 && busy_o == 0, "R5 empty pulse end", done_o, 0);
      return;
    end
    check(acc_valid_o == 1 && busy_o == 1, "R10 first access", acc_valid_o, 1);
    while (k < cnt && t < 2000) begin
      check(acc_valid_o == 1, "R4 valid held", acc_valid_o, 1);
      check(acc_reg_o == 4'(nb), "R2 reg order", acc_reg_o, nb);
      check(acc_addr_o == base + AW'(4 * k), "R3 address", acc_addr_o, base + AW'(4 * k));
      if (t < junk) begin
        r = 0; start_i = 1; reg_list_i = 16'hFFFF; base_i = 32'h9000;
      end else begin
        start_i = 0;
        r = (per == 0) ? 1'b1 : ((t % per) != 0);
      end
      mem_ready_i = r;
      @(negedge clk);
      t++;
      if (r) begin
        k++;
        nb = next_bit(lst, nb + 1);
      end
    end
    start_i = 0; mem_ready_i = 0;
    check(done_o == 1 && acc_valid_o == 0, "R5 done after last", {done_o, acc_valid_o}, 2'b10);
    check(wb_value_o == exp_fin, "R6 wb value", wb_value_o, exp_fin);
    check(wb_valid_o == wb, "R6 wb valid", wb_valid_o, wb);
    check(ret_o == (ld && lst[15]), "R9 return flag", ret_o, ld && lst[15]);
    @(negedge clk);
    check(done_o == 0 && ret_o == 0 && busy_o == 0, "R5 single pulse", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(acc_valid_o == 0 && done_o == 0 && wb_valid_o == 0 && ret_o == 0 && busy_o == 0,
          "R1 reset outputs", {acc_valid_o, done_o, wb_valid_o, ret_o, busy_o}, 0);
    check(wb_value_o == 0, "R1 reset wb value", wb_value_o, 0);
    for (int v = 0; v < NV; v++)
      run_seq(V_LIST[v], V_BASE[v], V_WB[v], V_LD[v], V_PER[v], V_EXP[v], 0);
    // R7 empty mask, with and without writeback
    run_seq(16'h0000, 32'h0000_3000, 1'b1, 1'b1, 0, 32'h0000_3000, 0);
    run_seq(16'h0000, 32'h0000_7004, 1'b0, 1'b0, 0, 32'h0000_7004, 0);
    // R8 start while busy is ignored
    run_seq(16'h0003, 32'h0000_0500, 1'b1, 1'b0, 0, 32'h0000_0508, 2);
    // R9 store with bit 15: no return flag
    run_seq(16'h8010, 32'h0000_0600, 1'b1, 1'b0, 2, 32'h0000_0608, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule